// File: doc/BRIEF.md
# USB OUT Endpoint Receive Buffer

This block holds the data of one host-to-device endpoint between the serial engine and the CPU. The serial engine writes the bytes of an incoming packet into a shared byte store. At the end of the packet it either commits the packet (good) or discards it (bad). A committed packet raises a packet-ready flag and exposes its length. The CPU pulls bytes one per read strobe and then releases the packet. It can release the packet by clearing the ready flag, by flushing it, or by letting an automatic clear fire once it has read exactly one maximum-size packet.

The configured maximum packet size sets the number of packet slots. A size of at most half the store gives two slots (double buffering). A larger size gives one slot. Once every slot holds a committed packet, the endpoint refuses further packets with a NAK indication and its contents stay as they are.

Top module: `usb_out_ep_rxbuf`

## Requirements
- R1: A good commit of an accepted packet sets `pkt_rdy_o` to 1 and shows the packet's byte count on `pkt_len_o` from the next cycle.
- R2: `cpu_data_o` presents the head packet's bytes in arrival order, and each `cpu_rd_i` strobe advances by one byte.
- R3: A bad commit discards the bytes written since the last commit. `pkt_rdy_o` and `pkt_len_o` do not change, and the next good packet is stored from the same place.
- R4: A clear strobe releases the head packet, including any bytes not yet read. If a second packet is stored, `pkt_rdy_o` stays 1 and `pkt_len_o` shows the second packet's length.
- R5: With `cfg_auto_clr_i` at 1, the head packet is released in the cycle the CPU reads its `cfg_maxp_i`-th byte. A shorter packet is not released by reading.
- R6: `dbl_buf_o` is 1 and two packets are held when `cfg_maxp_i` <= DEPTH/2 (32 by default). Otherwise one packet is held.
- R7: While every slot holds a packet, `sie_nak_o` is 1, and bytes and commits from the serial engine leave the stored packets unchanged.
- R8: A flush strobe discards the head packet, and `pkt_rdy_o` is then re-evaluated from the packets that remain.
- R9: After reset, `pkt_rdy_o`, `pkt_len_o` and `sie_nak_o` are 0.
- R10: Clear and flush strobes with no stored packet have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_maxp_i | input | CW (7) | Maximum packet size in bytes |
| cfg_auto_clr_i | input | 1 | Enables the automatic release after a full-size packet is read |
| sie_wr_i | input | 1 | Byte write strobe from the serial engine |
| sie_data_i | input | 8 | Received byte |
| sie_good_i | input | 1 | Commits the packet just written |
| sie_bad_i | input | 1 | Discards the packet just written |
| sie_nak_o | output | 1 | All slots are full, so a new packet is refused |
| cpu_rd_i | input | 1 | CPU byte read strobe |
| cpu_data_o | output | 8 | Current byte of the head packet |
| csr_clr_rdy_i | input | 1 | Software writes 0 to the ready flag |
| csr_flush_i | input | 1 | Software flush of the head packet |
| pkt_rdy_o | output | 1 | At least one committed packet is stored |
| pkt_len_o | output | CW (7) | Byte count of the head packet, 0 when none is stored |
| dbl_buf_o | output | 1 | Double-buffer mode is active |

## Verification
The bench stores two packets in double-buffer mode and clears the first. A design that lets a clear drop the ready flag unconditionally would wrongly report no data here. A bad packet followed by a short good one exposes a design that fails to roll back, because the length and the data come out shifted. Packets sent while the endpoint is full are checked for leaking into the store. The automatic clear is driven with a full-size packet, a short packet and back-to-back full-size packets, which catches an off-by-one on the release byte and a release that also fires on short packets.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  typedef logic [7:0] data_t;
  localparam int unsigned MAX_SLOTS = 2;
  localparam int unsigned QW = $clog2(MAX_SLOTS + 1);
  // release source, listed by priority
  typedef enum logic [1:0] {REL_NONE, REL_FLUSH, REL_CLR, REL_AUTO} rel_src_t;
endpackage

// File: rtl/usb_rx_mode.sv
module usb_rx_mode import usb_rx_pkg::*; #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = 7
) (
  input  logic [CW-1:0] maxp_i,
  output logic          dbl_o,
  output logic [QW-1:0] slots_o
);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  always_comb begin
    dbl_o   = (maxp_i <= HALF);
    slots_o = dbl_o ? QW'(MAX_SLOTS) : QW'(1);
  end
endmodule

// File: rtl/usb_rx_mem.sv
module usb_rx_mem import usb_rx_pkg::*; #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  data_t         wdata_i,
  input  logic [AW-1:0] raddr_i,
  output data_t         rdata_o
);
  data_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/usb_rx_lenq.sv
module usb_rx_lenq #(
  parameter int unsigned SLOTS = 2,
  parameter int unsigned LW    = 7,
  localparam int unsigned IW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned QW = $clog2(SLOTS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [LW-1:0] len_i,
  input  logic          pop_i,
  output logic [LW-1:0] head_o,
  output logic [QW-1:0] cnt_o
);
  logic [LW-1:0] ent_q [SLOTS];
  logic [IW-1:0] wi_q, ri_q;
  logic [QW-1:0] cnt_q;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
    return (i == IW'(SLOTS - 1)) ? '0 : i + IW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < SLOTS; k++) ent_q[k] <= '0;
      wi_q  <= '0;
      ri_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) begin
        ent_q[wi_q] <= len_i;
        wi_q        <= nxt(wi_q);
      end
      if (pop_i) ri_q <= nxt(ri_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + QW'(1);
        2'b01:   cnt_q <= cnt_q - QW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o = (cnt_q != '0) ? ent_q[ri_q] : '0;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/usb_out_ep_rxbuf.sv
module usb_out_ep_rxbuf import usb_rx_pkg::*; #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cfg_maxp_i,
  input  logic          cfg_auto_clr_i,
  input  logic          sie_wr_i,
  input  logic [7:0]    sie_data_i,
  input  logic          sie_good_i,
  input  logic          sie_bad_i,
  output logic          sie_nak_o,
  input  logic          cpu_rd_i,
  output logic [7:0]    cpu_data_o,
  input  logic          csr_clr_rdy_i,
  input  logic          csr_flush_i,
  output logic          pkt_rdy_o,
  output logic [CW-1:0] pkt_len_o,
  output logic          dbl_buf_o
);
  logic          dbl;
  logic [QW-1:0] slots, q_cnt;
  logic [CW-1:0] head_len;
  logic [AW-1:0] rx_base_q, rd_base_q;
  logic [CW-1:0] rx_len_q, rd_cnt_q;
  logic          rx_drop_q;
  logic          full, have, wr_ok, good_ok, rd_ok, auto_hit, rel;
  rel_src_t      rel_src;
  data_t         rdata;

  usb_rx_mode #(.DEPTH(DEPTH), .CW(CW)) u_mode (
    .maxp_i (cfg_maxp_i),
    .dbl_o  (dbl),
    .slots_o(slots)
  );

  always_comb begin
    full     = (q_cnt >= slots);
    have     = (q_cnt != '0);
    wr_ok    = sie_wr_i && !sie_good_i && !sie_bad_i && !full && !rx_drop_q
               && (rx_len_q < cfg_maxp_i) && (rx_len_q < CW'(DEPTH));
    good_ok  = sie_good_i && !sie_bad_i && !full && !rx_drop_q;
    rd_ok    = cpu_rd_i && have && (rd_cnt_q < head_len);
    auto_hit = cfg_auto_clr_i && rd_ok && ((rd_cnt_q + CW'(1)) == cfg_maxp_i);
  end

  // flush over clear over auto-clear; all gated by a stored packet
  always_comb begin
    rel_src = REL_NONE;
    if (have) begin
      if (csr_flush_i)        rel_src = REL_FLUSH;
      else if (csr_clr_rdy_i) rel_src = REL_CLR;
      else if (auto_hit)      rel_src = REL_AUTO;
    end
    rel = (rel_src != REL_NONE);
  end

  usb_rx_lenq #(.SLOTS(MAX_SLOTS), .LW(CW)) u_lenq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(good_ok),
    .len_i (rx_len_q),
    .pop_i (rel),
    .head_o(head_len),
    .cnt_o (q_cnt)
  );

  usb_rx_mem #(.DEPTH(DEPTH)) u_mem (
    .clk_i  (clk_i),
    .we_i   (wr_ok),
    .waddr_i(rx_base_q + rx_len_q[AW-1:0]),
    .wdata_i(sie_data_i),
    .raddr_i(rd_base_q + rd_cnt_q[AW-1:0]),
    .rdata_o(rdata)
  );

  // receive side: rx_base_q is the committed write point, rx_len_q the open packet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_base_q <= '0;
      rx_len_q  <= '0;
      rx_drop_q <= 1'b0;
    end else if (sie_good_i || sie_bad_i) begin
      rx_len_q  <= '0;
      rx_drop_q <= 1'b0;
      if (good_ok) rx_base_q <= rx_base_q + rx_len_q[AW-1:0];
    end else begin
      if (sie_wr_i && full) rx_drop_q <= 1'b1;
      if (wr_ok) rx_len_q <= rx_len_q + CW'(1);
    end
  end

  // read side: release skips whatever of the head packet is unread
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_base_q <= '0;
      rd_cnt_q  <= '0;
    end else if (rel) begin
      rd_base_q <= rd_base_q + head_len[AW-1:0];
      rd_cnt_q  <= '0;
    end else if (rd_ok) begin
      rd_cnt_q <= rd_cnt_q + CW'(1);
    end
  end

  assign sie_nak_o  = full;
  assign pkt_rdy_o  = have;
  assign pkt_len_o  = head_len;
  assign cpu_data_o = have ? rdata : 8'h00;
  assign dbl_buf_o  = dbl;
endmodule

// File: rtl/usb_out_ep_rxbuf_chk.sv
module usb_out_ep_rxbuf_chk #(
  parameter int unsigned CW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sie_good_i,
  input logic          sie_bad_i,
  input logic          sie_nak_o,
  input logic          cpu_rd_i,
  input logic          csr_clr_rdy_i,
  input logic          csr_flush_i,
  input logic          pkt_rdy_o,
  input logic [CW-1:0] pkt_len_o,
  input logic          dbl_buf_o,
  input logic          rx_drop
);
  p_good_sets_rdy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sie_good_i && !sie_bad_i && !sie_nak_o && !rx_drop |=> pkt_rdy_o);

  p_bad_keeps_state_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sie_bad_i && !csr_clr_rdy_i && !csr_flush_i && !cpu_rd_i
    |=> $stable(pkt_rdy_o) && $stable(pkt_len_o));

  p_dbl_release_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbl_buf_o && sie_nak_o && (csr_clr_rdy_i || csr_flush_i) |=> pkt_rdy_o);

  p_single_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbl_buf_o && pkt_rdy_o |-> sie_nak_o);

  p_idle_stays_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_rdy_o && !sie_good_i |=> !pkt_rdy_o);
endmodule

bind usb_out_ep_rxbuf usb_out_ep_rxbuf_chk #(.CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sie_good_i   (sie_good_i),
  .sie_bad_i    (sie_bad_i),
  .sie_nak_o    (sie_nak_o),
  .cpu_rd_i     (cpu_rd_i),
  .csr_clr_rdy_i(csr_clr_rdy_i),
  .csr_flush_i  (csr_flush_i),
  .pkt_rdy_o    (pkt_rdy_o),
  .pkt_len_o    (pkt_len_o),
  .dbl_buf_o    (dbl_buf_o),
  .rx_drop      (rx_drop_q)
);

// File: tb/usb_out_ep_rxbuf_tb_top.sv
module usb_out_ep_rxbuf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [CW-1:0] cfg_maxp_i = '0;
  logic cfg_auto_clr_i = 1'b0;
  logic sie_wr_i = 1'b0, sie_good_i = 1'b0, sie_bad_i = 1'b0;
  logic [7:0] sie_data_i = '0;
  logic cpu_rd_i = 1'b0, csr_clr_rdy_i = 1'b0, csr_flush_i = 1'b0;
  logic sie_nak_o, pkt_rdy_o, dbl_buf_o;
  logic [7:0] cpu_data_o;
  logic [CW-1:0] pkt_len_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  usb_out_ep_rxbuf #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_maxp_i(cfg_maxp_i), .cfg_auto_clr_i(cfg_auto_clr_i),
    .sie_wr_i(sie_wr_i), .sie_data_i(sie_data_i), .sie_good_i(sie_good_i), .sie_bad_i(sie_bad_i),
    .sie_nak_o(sie_nak_o), .cpu_rd_i(cpu_rd_i), .cpu_data_o(cpu_data_o),
    .csr_clr_rdy_i(csr_clr_rdy_i), .csr_flush_i(csr_flush_i),
    .pkt_rdy_o(pkt_rdy_o), .pkt_len_o(pkt_len_o), .dbl_buf_o(dbl_buf_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] model_b[$];
  int model_len[$];
  int rd_off = 0;
  logic [7:0] exp_q[$];
  logic chk_en = 1'b0;
  string cur_req = "R2";

  function automatic int slots_m();
    return (int'(cfg_maxp_i) <= DEPTH / 2) ? 2 : 1;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: compares each checked read against the queued byte
  always @(negedge clk) begin
    if (rst_ni && cpu_rd_i && chk_en) begin
      if (exp_q.size() == 0) check(cur_req, "unexpected read", 1, 0);
      else check(cur_req, "read byte", int'(cpu_data_o), int'(exp_q.pop_front()));
    end
  end

  task automatic model_release();
    if (model_len.size() > 0) begin
      for (int i = 0; i < model_len[0]; i++) void'(model_b.pop_front());
      void'(model_len.pop_front());
      rd_off = 0;
    end
  endtask

  task automatic check_state(string req);
    @(negedge clk);
    check(req, "pkt_rdy_o", int'(pkt_rdy_o), int'(model_len.size() > 0));
    check(req, "pkt_len_o", int'(pkt_len_o), (model_len.size() > 0) ? model_len[0] : 0);
    check(req, "sie_nak_o", int'(sie_nak_o), int'(model_len.size() >= slots_m()));
  endtask

  task automatic send_pkt(int n, int seed, bit good);
    logic [7:0] tmp[$];
    bit acc;
    acc = model_len.size() < slots_m();
    for (int i = 0; i < n; i++) begin
      sie_wr_i = 1'b1;
      sie_data_i = 8'(seed + 3 * i);
      if (acc) tmp.push_back(sie_data_i);
      @(posedge clk); #1;
    end
    sie_wr_i = 1'b0;
    sie_good_i = good;
    sie_bad_i = !good;
    @(posedge clk); #1;
    sie_good_i = 1'b0;
    sie_bad_i = 1'b0;
    if (good && acc) begin
      foreach (tmp[k]) model_b.push_back(tmp[k]);
      model_len.push_back(n);
    end
  endtask

  task automatic read_n(int n, string req);
    cur_req = req;
    for (int i = 0; i < n; i++) begin
      chk_en = (model_len.size() > 0) && (rd_off < model_len[0]);
      if (chk_en) exp_q.push_back(model_b[rd_off]);
      cpu_rd_i = 1'b1;
      @(posedge clk); #1;
      if (chk_en) begin
        rd_off++;
        if (cfg_auto_clr_i && rd_off == int'(cfg_maxp_i)) model_release();
      end
    end
    cpu_rd_i = 1'b0;
    chk_en = 1'b0;
  endtask

  task automatic pulse_clr();
    csr_clr_rdy_i = 1'b1;
    @(posedge clk); #1;
    csr_clr_rdy_i = 1'b0;
    model_release();
  endtask

  task automatic pulse_flush();
    csr_flush_i = 1'b1;
    @(posedge clk); #1;
    csr_flush_i = 1'b0;
    model_release();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cfg_maxp_i = CW'(8);
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    check_state("R9");

    // R1 R6: double buffering, first packet
    send_pkt(5, 8'h10, 1'b1);
    check_state("R1");
    check("R6", "dbl_buf_o", int'(dbl_buf_o), 1);
    // R7: second packet fills, third is refused
    send_pkt(8, 8'h40, 1'b1);
    check_state("R7");
    send_pkt(3, 8'h90, 1'b1);
    check_state("R7");
    // R2 R4: read first, clear keeps ready for second
    read_n(6, "R2");
    pulse_clr();
    check_state("R4");
    check("R4", "pkt_rdy_o held", int'(pkt_rdy_o), 1);
    check("R4", "second length", int'(pkt_len_o), 8);
    read_n(4, "R4");
    pulse_clr();
    check_state("R4");

    // R3: bad packet rolled back
    send_pkt(4, 8'h20, 1'b0);
    check_state("R3");
    send_pkt(2, 8'h70, 1'b1);
    check_state("R3");
    read_n(2, "R3");
    pulse_clr();

    // R5: automatic clear
    cfg_auto_clr_i = 1'b1;
    send_pkt(8, 8'h33, 1'b1);
    read_n(8, "R5");
    check_state("R5");
    check("R5", "released after full read", int'(pkt_rdy_o), 0);
    send_pkt(3, 8'h55, 1'b1);
    read_n(3, "R5");
    check_state("R5");
    check("R5", "short packet kept", int'(pkt_rdy_o), 1);
    pulse_clr();
    send_pkt(8, 8'h01, 1'b1);
    send_pkt(8, 8'hA0, 1'b1);
    read_n(8, "R5");
    check_state("R5");
    read_n(8, "R5");
    check_state("R5");
    cfg_auto_clr_i = 1'b0;

    // R6: single buffering
    cfg_maxp_i = CW'(40);
    @(negedge clk);
    check("R6", "dbl_buf_o", int'(dbl_buf_o), 0);
    send_pkt(40, 8'h07, 1'b1);
    check_state("R6");
    send_pkt(4, 8'hC0, 1'b1);
    check_state("R7");
    read_n(40, "R6");
    check_state("R6");
    pulse_clr();
    check_state("R6");

    // R8: flush
    cfg_maxp_i = CW'(8);
    send_pkt(3, 8'h11, 1'b1);
    send_pkt(6, 8'h61, 1'b1);
    pulse_flush();
    check_state("R8");
    read_n(6, "R8");
    pulse_flush();
    check_state("R8");

    // R10: strobes on empty endpoint
    pulse_flush();
    pulse_clr();
    check_state("R10");
    send_pkt(4, 8'hE0, 1'b1);
    check_state("R10");
    read_n(4, "R10");
    pulse_clr();

    repeat (3) @(posedge clk);
    check("R2", "scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule